// File: doc/BRIEF.md
# Linked-List Transmit DMA Engine

This block is a single-channel transmit DMA engine. Software places a chain of four-word descriptors in memory and starts the engine by writing the address of the first descriptor to a head register. The engine reads each descriptor over a simple memory master port that has one transaction in flight at a time. It then streams the referenced buffer out as bytes on a valid/ready port. When a descriptor is finished, the engine writes its control word back to memory with ownership returned to software.

The engine raises an interrupt whenever the most recently finished descriptor differs from the value software last wrote to the completion register. Software clears the interrupt by writing back the address of that descriptor. A descriptor can carry a flag that asks for a zero-length packet instead of data; the engine then emits a one-cycle strobe. A descriptor that software has not handed over stops the engine.

When a chain ends, the engine marks the final descriptor as end-of-queue. Software can then restart the engine by writing a new head pointer.

Top module: `txd_tx_dma`

## Requirements
- R1: After reset the engine is idle: `irq`, `st_valid`, `zlp_pulse` and `mem_req` are all low.
- R2: A register write with `reg_sel`=0 and nonzero data starts the engine when it is idle. The engine first reads the four descriptor words at head+0 (next pointer), head+4 (buffer pointer), head+8 (offset/length word) and head+12 (control word). A head write of zero is ignored, and so is a head write made while the engine is busy.
- R3: The engine emits the buffer bytes in ascending address order. Byte k sits in bits 8k+7..8k of the 32-bit word at an address with its two low bits cleared. The byte count is bits 15:0 of the offset/length word; bits 31:16 are ignored. A count of zero sends no bytes.
- R4: `st_last` is high on the final byte of a descriptor if, and only if, bit 30 (end-of-frame) of its control word is set. It is low on every other byte.
- R5: If bit 29 (ownership) of a fetched control word is clear, the engine sends nothing, writes nothing back, leaves `irq` unchanged and goes idle.
- R6: When a descriptor is finished, the engine writes its control word back to head+12. Bit 29 is cleared, and bit 28 (end-of-queue) is set exactly when the next pointer is zero. All other bits are kept.
- R7: After the write-back, a nonzero next pointer makes the engine fetch that descriptor. A zero next pointer returns the engine to idle.
- R8: If bit 23 of the control word is set (with ownership), the engine sends no data bytes. It pulses `zlp_pulse` high for exactly one cycle and then performs the write-back.
- R9: `irq` rises after a descriptor write-back. It stays high until a write with `reg_sel`=1 sets the completion pointer equal to the address of the last finished descriptor. Writing any other value leaves `irq` high.
- R10: After a chain has stopped, either at end-of-queue or at a descriptor software still owned, a new head write restarts processing at the new address.
- R11: A memory request holds its address and direction until `mem_ack`. A byte offered on the stream holds `st_data` and `st_last` until `st_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 head pointer, 1 completion pointer |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory transaction completes this cycle |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| st_valid | output | 1 | Stream byte valid |
| st_data | output | 8 | Stream byte |
| st_last | output | 1 | Final byte of an end-of-frame descriptor |
| st_ready | input | 1 | Stream sink accepts the byte |
| zlp_pulse | output | 1 | One-cycle zero-length-packet request |
| irq | output | 1 | Completion interrupt |

## Verification
Two conditions are the hardest to produce at the ports. The first is a head write that arrives while a chain is still in flight. The second is a chain that halts at a descriptor software has not yet handed over and is later restarted from that descriptor. To reach the first, the stimulus drops the sink's ready rate so that a 60-byte buffer takes many cycles, and it writes a second head pointer partway through. The bench then checks that the second descriptor was never fetched or retired. To reach the second, it links an owned descriptor to an unowned one, waits for the halt, sets the ownership bit in memory and writes the head again. Random chains with unaligned buffers, random lengths, end-of-frame flags and zero-length descriptors make up the rest of the stimulus, and memory latency is random.

// File: rtl/txd_pkg.sv
package txd_pkg;

    localparam int WORD_W    = 32;
    localparam int BYTE_W    = 8;
    localparam int LEN_W     = 16;
    localparam int WORD_BYTES = WORD_W / BYTE_W;
    localparam int LANE_W    = $clog2(WORD_BYTES);

    // control word bit positions
    localparam int CB_SOF = 31;
    localparam int CB_EOF = 30;
    localparam int CB_OWN = 29;
    localparam int CB_EOQ = 28;
    localparam int CB_ZLP = 23;

    // descriptor word offsets (the fetch order follows this layout)
    localparam logic [WORD_W-1:0] OFS_NEXT = WORD_W'(0);
    localparam logic [WORD_W-1:0] OFS_BUF  = WORD_W'(4);
    localparam logic [WORD_W-1:0] OFS_LEN  = WORD_W'(8);
    localparam logic [WORD_W-1:0] OFS_CTL  = WORD_W'(12);

    localparam logic SEL_HEAD = 1'b0;
    localparam logic SEL_CMPL = 1'b1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_NEXT,
        ST_RD_BUF,
        ST_RD_LEN,
        ST_RD_CTL,
        ST_DATA,
        ST_ZLP,
        ST_WB
    } eng_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] next_ptr;
        logic [WORD_W-1:0] buf_ptr;
        logic [LEN_W-1:0]  byte_len;
        logic [WORD_W-1:0] ctrl;
    } desc_t;

    // control word as returned to software on retirement
    function automatic logic [WORD_W-1:0] retire_ctrl(input logic [WORD_W-1:0] ctrl,
                                                      input logic end_of_chain);
        logic [WORD_W-1:0] r;
        r = ctrl;
        r[CB_OWN] = 1'b0;
        if (end_of_chain) r[CB_EOQ] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/txd_regs.sv
module txd_regs
    import txd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we_i,
    input  logic              reg_sel_i,
    input  logic [WORD_W-1:0] reg_wdata_i,
    input  logic              done_we_i,
    input  logic [WORD_W-1:0] done_ptr_i,
    output logic              start_o,
    output logic [WORD_W-1:0] start_ptr_o,
    output logic              irq_o
);

    logic [WORD_W-1:0] head_q;
    logic [WORD_W-1:0] cmpl_q;
    logic [WORD_W-1:0] done_q;
    logic              start_q;
    logic              head_wr;
    logic              cmpl_wr;

    assign head_wr = reg_we_i && (reg_sel_i == SEL_HEAD) && (reg_wdata_i != '0);
    assign cmpl_wr = reg_we_i && (reg_sel_i == SEL_CMPL);

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q  <= '0;
            cmpl_q  <= '0;
            done_q  <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= head_wr;
            if (head_wr)   head_q <= reg_wdata_i;
            if (cmpl_wr)   cmpl_q <= reg_wdata_i;
            if (done_we_i) done_q <= done_ptr_i;
        end
    end

    assign start_o     = start_q;
    assign start_ptr_o = head_q;
    assign irq_o       = (done_q != cmpl_q);

    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
        done_we_i && (done_ptr_i != cmpl_q) && !cmpl_wr |=> irq_o); // R9
    AST_IRQ_ACK: assert property (@(posedge clk) disable iff (rst)
        cmpl_wr && (reg_wdata_i == done_q) && !done_we_i |=> !irq_o); // R9

endmodule

// File: rtl/txd_streamer.sv
module txd_streamer
    import txd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [WORD_W-1:0] load_ptr_i,
    input  logic [LEN_W-1:0]  load_len_i,
    input  logic              load_eof_i,
    input  logic              word_valid_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              need_word_o,
    output logic [WORD_W-1:0] word_addr_o,
    output logic              idle_o,
    output logic              st_valid_o,
    output logic [BYTE_W-1:0] st_data_o,
    output logic              st_last_o,
    input  logic              st_ready_i
);

    logic [WORD_W-1:0] cur_q;
    logic [LEN_W-1:0]  remain_q;
    logic [WORD_W-1:0] word_q;
    logic              have_q;
    logic              active_q;
    logic              eof_q;
    logic              fire;
    logic [LANE_W-1:0] lane;

    assign lane        = cur_q[LANE_W-1:0];
    assign need_word_o = active_q && !have_q;
    assign word_addr_o = {cur_q[WORD_W-1:LANE_W], LANE_W'(0)};
    assign idle_o      = !active_q;
    assign st_valid_o  = active_q && have_q;
    assign st_data_o   = BYTE_W'(word_q >> (BYTE_W * lane));
    assign st_last_o   = eof_q && (remain_q == LEN_W'(1));
    assign fire        = st_valid_o && st_ready_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q    <= '0;
            remain_q <= '0;
            word_q   <= '0;
            have_q   <= 1'b0;
            active_q <= 1'b0;
            eof_q    <= 1'b0;
        end else if (load_i) begin
            cur_q    <= load_ptr_i;
            remain_q <= load_len_i;
            eof_q    <= load_eof_i;
            have_q   <= 1'b0;
            active_q <= (load_len_i != '0);
        end else begin
            if (word_valid_i) begin
                word_q <= word_i;
                have_q <= 1'b1;
            end
            if (fire) begin
                cur_q    <= cur_q + WORD_W'(1);
                remain_q <= remain_q - LEN_W'(1);
                if (remain_q == LEN_W'(1)) active_q <= 1'b0;
                if (lane == '1)            have_q   <= 1'b0;
            end
        end
    end

    AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (rst)
        st_valid_o && !st_ready_i |=> st_valid_o && $stable(st_data_o) && $stable(st_last_o)); // R11
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
        st_valid_o && st_ready_i && st_last_o |=> !st_valid_o); // R4

endmodule

// File: rtl/txd_engine.sv
module txd_engine
    import txd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [WORD_W-1:0] start_ptr_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [WORD_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic              load_o,
    output logic [WORD_W-1:0] load_ptr_o,
    output logic [LEN_W-1:0]  load_len_o,
    output logic              load_eof_o,
    input  logic              need_word_i,
    input  logic [WORD_W-1:0] word_addr_i,
    input  logic              stream_idle_i,
    output logic              word_valid_o,
    output logic              zlp_o,
    output logic              done_we_o,
    output logic [WORD_W-1:0] done_ptr_o
);

    eng_state_e        state_q;
    logic [WORD_W-1:0] desc_q;
    desc_t             dsc_q;
    logic              owned;
    logic              zlp_req;

    assign owned   = mem_rdata_i[CB_OWN];
    assign zlp_req = mem_rdata_i[CB_ZLP];

    always_comb begin
        mem_req_o  = 1'b0;
        mem_we_o   = 1'b0;
        mem_addr_o = desc_q;
        case (state_q)
            ST_RD_NEXT: begin mem_req_o = 1'b1; mem_addr_o = desc_q + OFS_NEXT; end
            ST_RD_BUF:  begin mem_req_o = 1'b1; mem_addr_o = desc_q + OFS_BUF;  end
            ST_RD_LEN:  begin mem_req_o = 1'b1; mem_addr_o = desc_q + OFS_LEN;  end
            ST_RD_CTL:  begin mem_req_o = 1'b1; mem_addr_o = desc_q + OFS_CTL;  end
            ST_DATA:    begin mem_req_o = need_word_i; mem_addr_o = word_addr_i; end
            ST_WB: begin
                mem_req_o  = 1'b1;
                mem_we_o   = 1'b1;
                mem_addr_o = desc_q + OFS_CTL;
            end
            default: ;
        endcase
    end

    assign mem_wdata_o  = retire_ctrl(dsc_q.ctrl, dsc_q.next_ptr == '0);
    assign load_o       = (state_q == ST_RD_CTL) && mem_ack_i && owned && !zlp_req;
    assign load_ptr_o   = dsc_q.buf_ptr;
    assign load_len_o   = dsc_q.byte_len;
    assign load_eof_o   = mem_rdata_i[CB_EOF];
    assign word_valid_o = (state_q == ST_DATA) && mem_ack_i;
    assign zlp_o        = (state_q == ST_ZLP);
    assign done_we_o    = (state_q == ST_WB) && mem_ack_i;
    assign done_ptr_o   = desc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            desc_q  <= '0;
            dsc_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start_i) begin
                    desc_q  <= start_ptr_i;
                    state_q <= ST_RD_NEXT;
                end
                ST_RD_NEXT: if (mem_ack_i) begin
                    dsc_q.next_ptr <= mem_rdata_i;
                    state_q        <= ST_RD_BUF;
                end
                ST_RD_BUF: if (mem_ack_i) begin
                    dsc_q.buf_ptr <= mem_rdata_i;
                    state_q       <= ST_RD_LEN;
                end
                ST_RD_LEN: if (mem_ack_i) begin
                    dsc_q.byte_len <= mem_rdata_i[LEN_W-1:0];
                    state_q        <= ST_RD_CTL;
                end
                ST_RD_CTL: if (mem_ack_i) begin
                    dsc_q.ctrl <= mem_rdata_i;
                    if (!owned)       state_q <= ST_IDLE;
                    else if (zlp_req) state_q <= ST_ZLP;
                    else              state_q <= ST_DATA;
                end
                ST_DATA: if (stream_idle_i) state_q <= ST_WB;
                ST_ZLP:  state_q <= ST_WB;
                ST_WB: if (mem_ack_i) begin
                    if (dsc_q.next_ptr != '0) begin
                        desc_q  <= dsc_q.next_ptr;
                        state_q <= ST_RD_NEXT;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R11
    AST_ZLP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        zlp_o |=> !zlp_o); // R8
    AST_DONE_AT_CTL: assert property (@(posedge clk) disable iff (rst)
        done_we_o |-> mem_we_o && (mem_addr_o == done_ptr_o + OFS_CTL)); // R6

endmodule

// File: rtl/txd_tx_dma.sv
module txd_tx_dma
    import txd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic              reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              st_valid,
    output logic [BYTE_W-1:0] st_data,
    output logic              st_last,
    input  logic              st_ready,
    output logic              zlp_pulse,
    output logic              irq
);

    logic              start;
    logic [WORD_W-1:0] start_ptr;
    logic              done_we;
    logic [WORD_W-1:0] done_ptr;
    logic              load;
    logic [WORD_W-1:0] load_ptr;
    logic [LEN_W-1:0]  load_len;
    logic              load_eof;
    logic              need_word;
    logic [WORD_W-1:0] word_addr;
    logic              stream_idle;
    logic              word_valid;

    txd_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .reg_we_i    (reg_we),
        .reg_sel_i   (reg_sel),
        .reg_wdata_i (reg_wdata),
        .done_we_i   (done_we),
        .done_ptr_i  (done_ptr),
        .start_o     (start),
        .start_ptr_o (start_ptr),
        .irq_o       (irq)
    );

    txd_engine u_engine (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start),
        .start_ptr_i   (start_ptr),
        .mem_req_o     (mem_req),
        .mem_we_o      (mem_we),
        .mem_addr_o    (mem_addr),
        .mem_wdata_o   (mem_wdata),
        .mem_ack_i     (mem_ack),
        .mem_rdata_i   (mem_rdata),
        .load_o        (load),
        .load_ptr_o    (load_ptr),
        .load_len_o    (load_len),
        .load_eof_o    (load_eof),
        .need_word_i   (need_word),
        .word_addr_i   (word_addr),
        .stream_idle_i (stream_idle),
        .word_valid_o  (word_valid),
        .zlp_o         (zlp_pulse),
        .done_we_o     (done_we),
        .done_ptr_o    (done_ptr)
    );

    txd_streamer u_stream (
        .clk          (clk),
        .rst          (rst),
        .load_i       (load),
        .load_ptr_i   (load_ptr),
        .load_len_i   (load_len),
        .load_eof_i   (load_eof),
        .word_valid_i (word_valid),
        .word_i       (mem_rdata),
        .need_word_o  (need_word),
        .word_addr_o  (word_addr),
        .idle_o       (stream_idle),
        .st_valid_o   (st_valid),
        .st_data_o    (st_data),
        .st_last_o    (st_last),
        .st_ready_i   (st_ready)
    );

    AST_ZLP_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        zlp_pulse |-> !st_valid); // R8
    AST_WB_NOT_DURING_DATA: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> !st_valid); // R6

endmodule

// File: tb/txd_tx_dma_tb_top.sv
`timescale 1ns/1ps
module txd_tx_dma_tb_top;

    localparam logic [31:0] B_EOF = 32'h4000_0000;
    localparam logic [31:0] B_OWN = 32'h2000_0000;
    localparam logic [31:0] B_EOQ = 32'h1000_0000;
    localparam logic [31:0] B_ZLP = 32'h0080_0000;
    localparam logic [31:0] B_SOF = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        st_valid, st_last, zlp_pulse, irq;
    logic [7:0]  st_data;
    logic        st_ready = 1'b0;

    txd_tx_dma dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .st_valid(st_valid), .st_data(st_data), .st_last(st_last), .st_ready(st_ready),
        .zlp_pulse(zlp_pulse), .irq(irq)
    );

    always #2 clk = ~clk;

    logic [31:0] mem [0:4095];
    logic [31:0] rd_log [0:7];
    logic [7:0]  rx_d [0:1023];
    logic        rx_l [0:1023];
    int rd_cnt = 0, wr_cnt = 0, rx_n = 0, zlp_n = 0, lat = 0;
    int n_chk = 0, n_fail = 0;
    bit slow = 0;

    // memory and stream sink model, all activity on the falling edge
    always @(negedge clk) begin
        if (rst) begin
            mem_ack  = 1'b0;
            st_ready = 1'b0;
            lat      = 0;
        end else begin
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req) begin
                if (lat > 0) lat--;
                else begin
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        mem[mem_addr[13:2]] = mem_wdata;
                        wr_cnt++;
                    end else begin
                        mem_rdata = mem[mem_addr[13:2]];
                        if (rd_cnt < 8) rd_log[rd_cnt] = mem_addr;
                        rd_cnt++;
                    end
                    lat = $urandom_range(0, 2);
                end
            end
            st_ready = slow ? ($urandom_range(0, 3) == 0) : ($urandom_range(0, 3) != 0);
            if (st_valid && st_ready) begin
                if (rx_n < 1024) begin
                    rx_d[rx_n] = st_data;
                    rx_l[rx_n] = st_last;
                end
                rx_n++;
            end
            if (zlp_pulse) zlp_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] nx, input logic [31:0] bp,
                            input logic [31:0] ol, input logic [31:0] ct);
        mem[a[13:2]]     = nx;
        mem[a[13:2] + 1] = bp;
        mem[a[13:2] + 2] = ol;
        mem[a[13:2] + 3] = ct;
    endtask

    function automatic logic [7:0] byte_at(input logic [31:0] a);
        logic [31:0] w;
        w = mem[a[13:2]];
        return w[a[1:0]*8 +: 8];
    endfunction

    task automatic clear_counts();
        rd_cnt = 0; wr_cnt = 0; rx_n = 0; zlp_n = 0;
    endtask

    task automatic wait_writes(input int n);
        while (wr_cnt < n) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic rand_test(input int t);
        logic [31:0] base, a, nx, bp, ct, ol;
        logic [31:0] exp_ct [0:2];
        logic [7:0]  ed [0:255];
        logic        el [0:255];
        int nd, en, ez, len, bad_d, bad_l;
        bit z, eof;
        nd = $urandom_range(1, 3);
        base = 32'h100 + 32'(t % 8) * 32'h40;
        en = 0; ez = 0;
        for (int k = 0; k < nd; k++) begin
            a   = base + 32'(k) * 16;
            nx  = (k == nd - 1) ? 32'h0 : a + 16;
            z   = ($urandom_range(0, 4) == 0);
            len = z ? 1 : $urandom_range(0, 60);
            bp  = 32'h1000 + 32'((t % 8) * 3 + k) * 32'h80 + 32'($urandom_range(0, 7));
            eof = $urandom_range(0, 1);
            ct  = B_OWN | (eof ? B_EOF : 32'h0) | (z ? B_ZLP : 32'h0)
                | ($urandom_range(0, 1) ? B_SOF : 32'h0) | 32'(len);
            ol  = (32'($urandom_range(0, 255)) << 16) | 32'(len);
            put_desc(a, nx, bp, ol, ct);
            exp_ct[k] = (ct & ~B_OWN) | ((nx == 0) ? B_EOQ : 32'h0);
            if (z) ez++;
            else for (int i = 0; i < len; i++) begin
                ed[en] = byte_at(bp + 32'(i));
                el[en] = eof && (i == len - 1);
                en++;
            end
        end
        clear_counts();
        reg_write(1'b0, base);
        wait_writes(nd);
        chk(rd_log[0] == base && rd_log[1] == base + 4 && rd_log[2] == base + 8 && rd_log[3] == base + 12,
            "R2 fetch order", rd_log[3], base + 12);
        chk(rx_n == en, "R3 byte count", 32'(rx_n), 32'(en));
        bad_d = 0; bad_l = 0;
        for (int i = 0; i < en && i < rx_n; i++) begin
            if (rx_d[i] != ed[i]) bad_d++;
            if (rx_l[i] != el[i]) bad_l++;
        end
        chk(bad_d == 0, "R3 byte data", 32'(bad_d), 32'h0);
        chk(bad_l == 0, "R4 last flag", 32'(bad_l), 32'h0);
        chk(zlp_n == ez, "R8 zlp pulses", 32'(zlp_n), 32'(ez));
        for (int k = 0; k < nd; k++) begin
            a = base + 32'(k) * 16 + 12;
            chk(mem[a[13:2]] == exp_ct[k], "R6 writeback", mem[a[13:2]], exp_ct[k]);
        end
        chk(wr_cnt == nd, "R7 chain length", 32'(wr_cnt), 32'(nd));
        chk(irq == 1'b1, "R9 irq raised", 32'(irq), 32'h1);
        reg_write(1'b1, base + 32'h4000);
        @(negedge clk);
        chk(irq == 1'b1, "R9 wrong ack keeps irq", 32'(irq), 32'h1);
        reg_write(1'b1, base + 32'(nd - 1) * 16);
        @(negedge clk);
        chk(irq == 1'b0, "R9 ack clears irq", 32'(irq), 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %h expected %h", 32'h1, 32'h0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < 4096; i++) mem[i] = $urandom;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(irq == 1'b0, "R1 irq", 32'(irq), 32'h0);
        chk(st_valid == 1'b0, "R1 st_valid", 32'(st_valid), 32'h0);
        chk(zlp_pulse == 1'b0, "R1 zlp", 32'(zlp_pulse), 32'h0);
        chk(mem_req == 1'b0, "R1 mem_req", 32'(mem_req), 32'h0);

        // R2 zero head ignored
        clear_counts();
        reg_write(1'b0, 32'h0);
        repeat (20) @(negedge clk);
        chk(rd_cnt == 0, "R2 zero head ignored", 32'(rd_cnt), 32'h0);

        // R5 refused descriptor
        put_desc(32'h300, 32'h0, 32'h2000, 32'd4, B_EOF | 32'd4);
        clear_counts();
        reg_write(1'b0, 32'h300);
        repeat (40) @(negedge clk);
        chk(rd_cnt == 4 && wr_cnt == 0, "R5 refused no writeback", 32'(wr_cnt), 32'h0);
        chk(rx_n == 0 && irq == 1'b0, "R5 refused no data/irq", 32'(rx_n), 32'h0);
        chk(mem[12'h0C3] == (B_EOF | 32'd4), "R5 refused ctrl untouched", mem[12'h0C3], B_EOF | 32'd4);

        // R7 halt at unowned successor, R10 restart there
        put_desc(32'h340, 32'h350, 32'h2101, 32'd5, B_OWN | 32'd5);
        put_desc(32'h350, 32'h0, 32'h2203, 32'd3, B_EOF | 32'd3);
        clear_counts();
        reg_write(1'b0, 32'h340);
        wait_writes(1);
        repeat (30) @(negedge clk);
        chk(wr_cnt == 1 && rx_n == 5, "R7 stop at unowned", 32'(wr_cnt), 32'h1);
        chk(mem[12'h0D3] == 32'd5, "R6 no eoq mid chain", mem[12'h0D3], 32'd5);
        chk(irq == 1'b1, "R9 irq after first", 32'(irq), 32'h1);
        reg_write(1'b1, 32'h340);
        mem[12'h0D7] = mem[12'h0D7] | B_OWN;
        reg_write(1'b0, 32'h350);
        wait_writes(2);
        chk(rx_n == 8 && rx_l[7] == 1'b1, "R10 restart data", 32'(rx_n), 32'd8);
        chk(mem[12'h0D7] == (B_EOF | B_EOQ | 32'd3), "R10 restart eoq", mem[12'h0D7], B_EOF | B_EOQ | 32'd3);
        reg_write(1'b1, 32'h350);

        // R2 head write while busy is ignored
        put_desc(32'h380, 32'h0, 32'h2302, 32'h00AB_003C, B_OWN | 32'd60);
        put_desc(32'h390, 32'h0, 32'h2400, 32'd4, B_OWN | 32'd4);
        slow = 1;
        clear_counts();
        reg_write(1'b0, 32'h380);
        repeat (10) @(negedge clk);
        reg_write(1'b0, 32'h390);
        wait_writes(1);
        repeat (30) @(negedge clk);
        slow = 0;
        chk(wr_cnt == 1 && rx_n == 60, "R2 busy head ignored", 32'(rx_n), 32'd60);
        chk(mem[12'h0E7] == (B_OWN | 32'd4), "R2 busy head not retired", mem[12'h0E7], B_OWN | 32'd4);
        reg_write(1'b1, 32'h380);
        @(negedge clk);
        chk(irq == 1'b0, "R9 ack", 32'(irq), 32'h0);

        for (int t = 0; t < 24; t++) rand_test(t);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule